// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block manages the receive side of a DMA descriptor ring. Software fills a table of descriptors in advance. Each descriptor holds a 32-bit status word and a 64-bit buffer address split into a low word and a high word. Software sets the status word to a 2048-byte buffer length with the ownership bit set.

When a frame arrives, the block does four things. It takes the descriptor at its current ring slot and presents that descriptor's buffer address as the write address for the data path. It writes the frame length back into the status word. It then advances both its ring slot and its 16-bit producer index. Software sees that a frame is waiting when the producer and consumer indices differ. It returns a buffer by writing the incremented consumer index.

An option places data two bytes into each buffer so that the IP header lands on a word boundary. With that option on, the written address and the reported length both include the two-byte pad. If every descriptor is in use, an incoming frame is dropped and a drop counter advances. A pause request (xoff) follows the count of free descriptors, with hysteresis set by two programmable thresholds.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset, the producer index, consumer index, ring slot and drop count are all zero, and xoff is low.
- R2: A software write stores `sw_wr_data` in word `sw_wr_word` of descriptor `sw_wr_slot`. The word codes are 0 for status, 1 for address low and 2 for address high. `sw_rd_data` returns the selected word combinationally. Code 3 ignores writes and reads as zero.
- R3: An accepted frame updates the status word of the descriptor at the current slot on the next clock edge. The new status holds the reported length in bits 27:16, bit 15 (ownership) clear, bits 14 and 13 (end and start of frame) set, and all other bits zero. The address words of that descriptor do not change.
- R4: `buf_addr` equals {address high, address low} of the descriptor at the current slot. When `align_en` is 1, `buf_addr` is 2 greater, and the reported length is `frm_len + 2`, truncated to 12 bits.
- R5: The producer index increments by one, modulo 2^16, for each accepted frame. `pending` is high exactly when the producer index differs from the consumer index.
- R6: A consumer write loads `cons_wr_val` into the consumer index on the next edge.
- R7: The ring slot advances by one for each accepted frame and wraps from 255 to 0. It is not affected by loads of either index.
- R8: `ring_full` is high when producer minus consumer (modulo 2^16) is at least 256. A frame that arrives while the ring is full is dropped. A dropped frame leaves the indices, the ring slot and every descriptor unchanged, and it increments `drop_cnt`.
- R9: xoff is updated in the same cycle as the indices. It rises when the number of free descriptors is at or below the low threshold (`fc_thresh[31:16]`). It falls only when the number of free descriptors rises above the high threshold (`fc_thresh[15:0]`).
- R10: `prod_load_en` loads `prod_load_val` into the producer index. A load takes precedence over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en | input | 1 | Software descriptor write strobe |
| sw_wr_slot | input | 8 | Descriptor number for the write |
| sw_wr_word | input | 2 | Word select: 0 status, 1 addr low, 2 addr high, 3 none |
| sw_wr_data | input | 32 | Write data |
| sw_rd_slot | input | 8 | Descriptor number for the read |
| sw_rd_word | input | 2 | Word select for the read |
| sw_rd_data | output | 32 | Read data (combinational) |
| cons_wr_en | input | 1 | Consumer index write strobe |
| cons_wr_val | input | 16 | New consumer index |
| prod_load_en | input | 1 | Producer index load strobe |
| prod_load_val | input | 16 | Producer index load value |
| align_en | input | 1 | Two-byte alignment pad enable |
| fc_thresh | input | 32 | Low threshold in 31:16, high threshold in 15:0 |
| frm_valid | input | 1 | One-cycle pulse marking a received frame |
| frm_len | input | 12 | Received frame length in bytes |
| buf_addr | output | 64 | Write address for the current descriptor |
| prod_idx | output | 16 | Producer index |
| cons_idx | output | 16 | Consumer index |
| ring_pos | output | 8 | Current ring slot |
| pending | output | 1 | At least one frame waits for software |
| ring_full | output | 1 | No free descriptor |
| xoff | output | 1 | Pause request from flow control |
| drop_cnt | output | 16 | Count of dropped frames |

## Verification
On every cycle, the bound checker verifies the following. The producer index and ring slot step by exactly one per accepted frame and hold otherwise. A frame arriving while the ring is full leaves the producer unchanged and bumps the drop count. Every rising or falling edge of xoff matches the free count seen at the ports.

Some behaviour can only be shown by the bench's scenarios, which it compares cycle by cycle against its reference model:
- the exact status word written back, including the alignment pad, and that the address words are left untouched;
- the wrap of the 16-bit indices through zero;
- the full-ring drop leaving the descriptors intact;
- the hysteresis band under two different threshold settings.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;

  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 3;
  localparam int LEN_W      = 12;
  localparam int ST_LEN_LSB = 16;
  localparam int ST_OWN_BIT = 15;
  localparam int ST_EOP_BIT = 14;
  localparam int ST_SOP_BIT = 13;

  typedef enum logic [1:0] {
    WSEL_STATUS  = 2'd0,
    WSEL_ADDR_LO = 2'd1,
    WSEL_ADDR_HI = 2'd2,
    WSEL_NONE    = 2'd3
  } wsel_e;

  // Status word written back for a frame that occupies a single buffer.
  function automatic logic [WORD_W-1:0] wb_status(input logic [LEN_W-1:0] len);
    logic [WORD_W-1:0] st;
    st = '0;
    st[ST_LEN_LSB +: LEN_W] = len;
    st[ST_OWN_BIT] = 1'b0;
    st[ST_EOP_BIT] = 1'b1;
    st[ST_SOP_BIT] = 1'b1;
    return st;
  endfunction

endpackage

// File: rtl/rxr_desc_store.sv
`timescale 1ns/1ps
module rxr_desc_store
  import rxr_pkg::*;
#(
  parameter int N_DESC = 256,
  parameter int SLOT_W = $clog2(N_DESC)
) (
  input  logic              clk,
  input  logic              sw_wr_en,
  input  logic [SLOT_W-1:0] sw_wr_slot,
  input  logic [1:0]        sw_wr_word,
  input  logic [WORD_W-1:0] sw_wr_data,
  input  logic              hw_wb_en,
  input  logic [SLOT_W-1:0] hw_wb_slot,
  input  logic [WORD_W-1:0] hw_wb_data,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [1:0]        rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic [SLOT_W-1:0] cur_slot,
  output logic [2*WORD_W-1:0] cur_addr
);

  logic [WORD_W-1:0] rd_q  [DESC_WORDS];
  logic [WORD_W-1:0] cur_q [DESC_WORDS];

  for (genvar gw = 0; gw < DESC_WORDS; gw++) begin : g_word
    logic [WORD_W-1:0] arr [N_DESC];
    logic              we;
    logic [SLOT_W-1:0] ws;
    logic [WORD_W-1:0] wd;

    if (gw == int'(WSEL_STATUS)) begin : g_status
      // The frame write-back wins over a software write in the same cycle.
      always_comb begin
        we = sw_wr_en && (sw_wr_word == 2'(gw));
        ws = sw_wr_slot;
        wd = sw_wr_data;
        if (hw_wb_en) begin
          we = 1'b1;
          ws = hw_wb_slot;
          wd = hw_wb_data;
        end
      end
    end else begin : g_addr
      always_comb begin
        we = sw_wr_en && (sw_wr_word == 2'(gw));
        ws = sw_wr_slot;
        wd = sw_wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (we) begin
        arr[ws] <= wd;
      end
    end

    assign rd_q[gw]  = arr[rd_slot];
    assign cur_q[gw] = arr[cur_slot];
  end

  always_comb begin
    case (wsel_e'(rd_word))
      WSEL_STATUS:  rd_data = rd_q[0];
      WSEL_ADDR_LO: rd_data = rd_q[1];
      WSEL_ADDR_HI: rd_data = rd_q[2];
      default:      rd_data = '0;
    endcase
  end

  assign cur_addr = {cur_q[int'(WSEL_ADDR_HI)], cur_q[int'(WSEL_ADDR_LO)]};

endmodule

// File: rtl/rxr_index_ctrl.sv
`timescale 1ns/1ps
module rxr_index_ctrl #(
  parameter int N_DESC = 256,
  parameter int IDX_W  = 16,
  parameter int CNT_W  = 16,
  parameter int SLOT_W = $clog2(N_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic              cons_wr_en,
  input  logic [IDX_W-1:0]  cons_wr_val,
  input  logic              prod_load_en,
  input  logic [IDX_W-1:0]  prod_load_val,
  output logic [IDX_W-1:0]  prod_idx,
  output logic [IDX_W-1:0]  cons_idx,
  output logic [SLOT_W-1:0] ring_pos,
  output logic              ring_full,
  output logic              frm_accept,
  output logic [IDX_W-1:0]  occ_nxt,
  output logic [CNT_W-1:0]  drop_cnt
);

  localparam logic [IDX_W-1:0]  N_W      = IDX_W'(N_DESC);
  localparam logic [SLOT_W-1:0] LAST_POS = SLOT_W'(N_DESC - 1);

  logic [IDX_W-1:0]  prod_q, prod_d;
  logic [IDX_W-1:0]  cons_q, cons_d;
  logic [SLOT_W-1:0] pos_q,  pos_d;
  logic [CNT_W-1:0]  drop_q, drop_d;
  logic [IDX_W-1:0]  occ;
  logic              drop_en;

  always_comb begin
    occ        = prod_q - cons_q;
    ring_full  = (occ >= N_W);
    frm_accept = frm_valid && !ring_full;
    drop_en    = frm_valid && ring_full;

    prod_d = prod_q;
    if (frm_accept)   prod_d = prod_q + IDX_W'(1);
    if (prod_load_en) prod_d = prod_load_val;

    cons_d = cons_wr_en ? cons_wr_val : cons_q;

    pos_d = pos_q;
    if (frm_accept) pos_d = (pos_q == LAST_POS) ? '0 : pos_q + SLOT_W'(1);

    drop_d  = drop_en ? drop_q + CNT_W'(1) : drop_q;
    occ_nxt = prod_d - cons_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      cons_q <= '0;
      pos_q  <= '0;
      drop_q <= '0;
    end else begin
      prod_q <= prod_d;
      cons_q <= cons_d;
      pos_q  <= pos_d;
      drop_q <= drop_d;
    end
  end

  assign prod_idx = prod_q;
  assign cons_idx = cons_q;
  assign ring_pos = pos_q;
  assign drop_cnt = drop_q;

endmodule

// File: rtl/rxr_flow_ctrl.sv
`timescale 1ns/1ps
module rxr_flow_ctrl #(
  parameter int N_DESC = 256,
  parameter int IDX_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] occ_nxt,
  input  logic [IDX_W-1:0] thr_lo,
  input  logic [IDX_W-1:0] thr_hi,
  output logic             xoff
);

  localparam logic [IDX_W-1:0] N_W = IDX_W'(N_DESC);

  logic [IDX_W-1:0] free_nxt;
  logic             xoff_q, xoff_d;

  always_comb begin
    free_nxt = (occ_nxt >= N_W) ? '0 : N_W - occ_nxt;
    if (xoff_q) xoff_d = (free_nxt <= thr_hi);
    else        xoff_d = (free_nxt <= thr_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xoff_q <= 1'b0;
    else        xoff_q <= xoff_d;
  end

  assign xoff = xoff_q;

endmodule

// File: rtl/rx_desc_ring.sv
`timescale 1ns/1ps
module rx_desc_ring
  import rxr_pkg::*;
#(
  parameter int N_DESC    = 256,
  parameter int IDX_W     = 16,
  parameter int CNT_W     = 16,
  parameter int ALIGN_PAD = 2,
  parameter int SLOT_W    = $clog2(N_DESC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_wr_en,
  input  logic [SLOT_W-1:0]    sw_wr_slot,
  input  logic [1:0]           sw_wr_word,
  input  logic [WORD_W-1:0]    sw_wr_data,
  input  logic [SLOT_W-1:0]    sw_rd_slot,
  input  logic [1:0]           sw_rd_word,
  output logic [WORD_W-1:0]    sw_rd_data,
  input  logic                 cons_wr_en,
  input  logic [IDX_W-1:0]     cons_wr_val,
  input  logic                 prod_load_en,
  input  logic [IDX_W-1:0]     prod_load_val,
  input  logic                 align_en,
  input  logic [2*IDX_W-1:0]   fc_thresh,
  input  logic                 frm_valid,
  input  logic [LEN_W-1:0]     frm_len,
  output logic [2*WORD_W-1:0]  buf_addr,
  output logic [IDX_W-1:0]     prod_idx,
  output logic [IDX_W-1:0]     cons_idx,
  output logic [SLOT_W-1:0]    ring_pos,
  output logic                 pending,
  output logic                 ring_full,
  output logic                 xoff,
  output logic [CNT_W-1:0]     drop_cnt
);

  logic                  frm_accept;
  logic [IDX_W-1:0]      occ_nxt;
  logic [LEN_W-1:0]      len_rep;
  logic [WORD_W-1:0]     wb_data;
  logic [2*WORD_W-1:0]   cur_addr;

  rxr_index_ctrl #(
    .N_DESC(N_DESC), .IDX_W(IDX_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
  ) u_idx (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_valid    (frm_valid),
    .cons_wr_en   (cons_wr_en),
    .cons_wr_val  (cons_wr_val),
    .prod_load_en (prod_load_en),
    .prod_load_val(prod_load_val),
    .prod_idx     (prod_idx),
    .cons_idx     (cons_idx),
    .ring_pos     (ring_pos),
    .ring_full    (ring_full),
    .frm_accept   (frm_accept),
    .occ_nxt      (occ_nxt),
    .drop_cnt     (drop_cnt)
  );

  always_comb begin
    len_rep  = frm_len + (align_en ? LEN_W'(ALIGN_PAD) : '0);
    wb_data  = wb_status(len_rep);
    buf_addr = cur_addr + (align_en ? (2*WORD_W)'(ALIGN_PAD) : '0);
  end

  rxr_desc_store #(
    .N_DESC(N_DESC), .SLOT_W(SLOT_W)
  ) u_store (
    .clk        (clk),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_slot (sw_wr_slot),
    .sw_wr_word (sw_wr_word),
    .sw_wr_data (sw_wr_data),
    .hw_wb_en   (frm_accept),
    .hw_wb_slot (ring_pos),
    .hw_wb_data (wb_data),
    .rd_slot    (sw_rd_slot),
    .rd_word    (sw_rd_word),
    .rd_data    (sw_rd_data),
    .cur_slot   (ring_pos),
    .cur_addr   (cur_addr)
  );

  rxr_flow_ctrl #(
    .N_DESC(N_DESC), .IDX_W(IDX_W)
  ) u_flow (
    .clk    (clk),
    .rst_n  (rst_n),
    .occ_nxt(occ_nxt),
    .thr_lo (fc_thresh[2*IDX_W-1:IDX_W]),
    .thr_hi (fc_thresh[IDX_W-1:0]),
    .xoff   (xoff)
  );

  assign pending = (prod_idx != cons_idx);

endmodule

// File: rtl/rx_desc_ring_chk.sv
`timescale 1ns/1ps
module rx_desc_ring_chk #(
  parameter int N_DESC = 256,
  parameter int IDX_W  = 16,
  parameter int CNT_W  = 16,
  parameter int SLOT_W = $clog2(N_DESC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frm_valid,
  input logic               prod_load_en,
  input logic               ring_full,
  input logic [IDX_W-1:0]   prod_idx,
  input logic [IDX_W-1:0]   cons_idx,
  input logic [SLOT_W-1:0]  ring_pos,
  input logic [CNT_W-1:0]   drop_cnt,
  input logic               xoff,
  input logic [2*IDX_W-1:0] fc_thresh
);

  localparam logic [IDX_W-1:0] N_W = IDX_W'(N_DESC);

  logic [IDX_W-1:0] occ_now, free_now;
  always_comb begin
    occ_now  = prod_idx - cons_idx;
    free_now = (occ_now >= N_W) ? '0 : N_W - occ_now;
  end

  p_prod_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !ring_full && !prod_load_en |=> prod_idx == $past(prod_idx) + IDX_W'(1));

  p_prod_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid && !prod_load_en |=> $stable(prod_idx));

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && ring_full && !prod_load_en |=>
      $stable(prod_idx) && drop_cnt == $past(drop_cnt) + CNT_W'(1));

  p_pos_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_valid && !ring_full) |=> $stable(ring_pos));

  p_xoff_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff) |-> free_now <= fc_thresh[2*IDX_W-1:IDX_W]);

  p_xoff_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xoff) |-> free_now > fc_thresh[IDX_W-1:0]);

endmodule

bind rx_desc_ring rx_desc_ring_chk #(
  .N_DESC(N_DESC), .IDX_W(IDX_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frm_valid   (frm_valid),
  .prod_load_en(prod_load_en),
  .ring_full   (ring_full),
  .prod_idx    (prod_idx),
  .cons_idx    (cons_idx),
  .ring_pos    (ring_pos),
  .drop_cnt    (drop_cnt),
  .xoff        (xoff),
  .fc_thresh   (fc_thresh)
);

// File: tb/rx_desc_ring_bench.sv
`timescale 1ns/1ps
module rx_desc_ring_bench;

  localparam int N = 256;

  logic        clk;
  logic        rst_n;
  logic        sw_wr_en;
  logic [7:0]  sw_wr_slot;
  logic [1:0]  sw_wr_word;
  logic [31:0] sw_wr_data;
  logic [7:0]  sw_rd_slot;
  logic [1:0]  sw_rd_word;
  logic [31:0] sw_rd_data;
  logic        cons_wr_en;
  logic [15:0] cons_wr_val;
  logic        prod_load_en;
  logic [15:0] prod_load_val;
  logic        align_en;
  logic [31:0] fc_thresh;
  logic        frm_valid;
  logic [11:0] frm_len;
  logic [63:0] buf_addr;
  logic [15:0] prod_idx, cons_idx;
  logic [7:0]  ring_pos;
  logic        pending, ring_full, xoff;
  logic [15:0] drop_cnt;

  rx_desc_ring u_rx_desc_ring (
    .clk(clk), .rst_n(rst_n),
    .sw_wr_en(sw_wr_en), .sw_wr_slot(sw_wr_slot), .sw_wr_word(sw_wr_word),
    .sw_wr_data(sw_wr_data), .sw_rd_slot(sw_rd_slot), .sw_rd_word(sw_rd_word),
    .sw_rd_data(sw_rd_data), .cons_wr_en(cons_wr_en), .cons_wr_val(cons_wr_val),
    .prod_load_en(prod_load_en), .prod_load_val(prod_load_val),
    .align_en(align_en), .fc_thresh(fc_thresh), .frm_valid(frm_valid),
    .frm_len(frm_len), .buf_addr(buf_addr), .prod_idx(prod_idx),
    .cons_idx(cons_idx), .ring_pos(ring_pos), .pending(pending),
    .ring_full(ring_full), .xoff(xoff), .drop_cnt(drop_cnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  bit  preloaded = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  int unsigned m_st [N];
  int unsigned m_lo [N];
  int unsigned m_hi [N];
  int m_prod, m_cons, m_pos, m_drop;
  bit m_xoff;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prod = 0; m_cons = 0; m_pos = 0; m_drop = 0; m_xoff = 0;
    end else begin
      int occ, free, np, nc, lenr;
      bit acc;
      acc = 0;
      occ = (m_prod - m_cons) & 'hFFFF;
      if (frm_valid) begin
        if (occ < N) begin
          acc  = 1;
          lenr = (int'(frm_len) + (align_en ? 2 : 0)) & 'hFFF;
          m_st[m_pos] = (lenr << 16) | 'h6000;
        end else begin
          m_drop = (m_drop + 1) & 'hFFFF;
        end
      end
      if (sw_wr_en && !(acc && sw_wr_word == 2'd0 && int'(sw_wr_slot) == m_pos)) begin
        case (sw_wr_word)
          2'd0: m_st[sw_wr_slot] = sw_wr_data;
          2'd1: m_lo[sw_wr_slot] = sw_wr_data;
          2'd2: m_hi[sw_wr_slot] = sw_wr_data;
          default: ;
        endcase
      end
      np = acc ? ((m_prod + 1) & 'hFFFF) : m_prod;
      if (prod_load_en) np = int'(prod_load_val);
      nc = cons_wr_en ? int'(cons_wr_val) : m_cons;
      if (acc) m_pos = (m_pos + 1) % N;
      m_prod = np;
      m_cons = nc;
      occ  = (np - nc) & 'hFFFF;
      free = (occ >= N) ? 0 : N - occ;
      m_xoff = m_xoff ? (free <= int'(fc_thresh[15:0])) : (free <= int'(fc_thresh[31:16]));
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [63:0] ea;
      chk("R5 prod_idx",  64'(prod_idx),  64'(m_prod));
      chk("R6 cons_idx",  64'(cons_idx),  64'(m_cons));
      chk("R7 ring_pos",  64'(ring_pos),  64'(m_pos));
      chk("R5 pending",   64'(pending),   64'(m_prod != m_cons));
      chk("R8 ring_full", 64'(ring_full), 64'(((m_prod - m_cons) & 'hFFFF) >= N));
      chk("R8 drop_cnt",  64'(drop_cnt),  64'(m_drop));
      chk("R9 xoff",      64'(xoff),      64'(m_xoff));
      if (preloaded) begin
        ea = {m_hi[m_pos], m_lo[m_pos]} + (align_en ? 64'd2 : 64'd0);
        chk("R4 buf_addr", buf_addr, ea);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input int len);
    frm_valid = 1'b1;
    frm_len   = 12'(len);
    step();
    frm_valid = 1'b0;
  endtask

  task automatic consume();
    cons_wr_en  = 1'b1;
    cons_wr_val = cons_idx + 16'd1;
    step();
    cons_wr_en  = 1'b0;
  endtask

  task automatic rd(input int slot, input int word, output logic [31:0] d);
    sw_rd_slot = 8'(slot);
    sw_rd_word = 2'(word);
    #0.2;
    d = sw_rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  pos_before;
    sw_wr_en = 0; sw_wr_slot = 0; sw_wr_word = 0; sw_wr_data = 0;
    sw_rd_slot = 0; sw_rd_word = 0;
    cons_wr_en = 0; cons_wr_val = 0; prod_load_en = 0; prod_load_val = 0;
    align_en = 0; fc_thresh = {16'd5, 16'd16}; frm_valid = 0; frm_len = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    step();

    // R1: reset state
    chk("R1 prod", 64'(prod_idx), 0);
    chk("R1 cons", 64'(cons_idx), 0);
    chk("R1 pos",  64'(ring_pos), 0);
    chk("R1 drop", 64'(drop_cnt), 0);
    chk("R1 xoff", 64'(xoff), 0);

    // Preload descriptors: R2
    for (int s = 0; s < N; s++) begin
      for (int w = 0; w < 3; w++) begin
        sw_wr_en = 1; sw_wr_slot = 8'(s); sw_wr_word = 2'(w);
        sw_wr_data = (w == 0) ? 32'h0800_8000 :
                     (w == 1) ? 32'h1000_0000 + 32'(s * 2048) : 32'(s);
        step();
      end
    end
    sw_wr_en = 0;
    preloaded = 1;
    rd(7, 1, d);  chk("R2 addr lo readback", 64'(d), 64'h1000_3800);
    rd(7, 0, d);  chk("R2 status readback", 64'(d), 64'h0800_8000);
    rd(7, 3, d);  chk("R2 word 3 reads zero", 64'(d), 0);

    // R3: write-back without alignment
    send(60); send(1514); send(100);
    rd(0, 0, d);  chk("R3 status slot0", 64'(d), 64'h003C_6000);
    rd(1, 0, d);  chk("R3 status slot1", 64'(d), 64'h05EA_6000);
    rd(1, 2, d);  chk("R3 addr hi untouched", 64'(d), 64'd1);
    rd(2, 1, d);  chk("R3 addr lo untouched", 64'(d), 64'h1000_1000);
    chk("R5 pending after frames", 64'(pending), 1);
    consume(); consume(); consume();
    chk("R6 cons after returns", 64'(cons_idx), 3);
    chk("R5 pending cleared", 64'(pending), 0);

    // R4: alignment pad
    align_en = 1;
    #0.2;
    chk("R4 aligned address", buf_addr, 64'h0000_0003_1000_1802);
    send(100); send(100);
    rd(3, 0, d);  chk("R4 padded length", 64'(d), 64'h0066_6000);
    consume(); consume();

    // R7/R8/R9: fill the whole ring
    for (int i = 0; i < N; i++) send(64);
    chk("R8 full", 64'(ring_full), 1);
    chk("R9 xoff on full", 64'(xoff), 1);
    chk("R7 wrapped slot", 64'(ring_pos), 5);
    rd(5, 0, d);  chk("R3 slot5 written by fill", 64'(d), 64'h0042_6000);
    send(200); send(200);
    chk("R8 drops counted", 64'(drop_cnt), 2);
    chk("R8 prod held", 64'(prod_idx), 16'd261);
    chk("R8 slot held", 64'(ring_pos), 5);
    rd(5, 0, d);  chk("R8 descriptor untouched by drop", 64'(d), 64'h0042_6000);

    // R9 hysteresis on release
    while (16'(prod_idx - cons_idx) > 16'd240) consume();
    chk("R9 xoff held at free=high", 64'(xoff), 1);
    consume();
    chk("R9 xoff released above high", 64'(xoff), 0);
    while (pending) consume();

    // R10: index load, 16-bit wrap independent of the slot
    pos_before = ring_pos;
    prod_load_en = 1; prod_load_val = 16'hFFFE;
    cons_wr_en = 1;   cons_wr_val = 16'hFFFE;
    step();
    prod_load_en = 0; cons_wr_en = 0;
    chk("R10 prod loaded", 64'(prod_idx), 64'h0000_FFFE);
    chk("R7 slot unaffected by load", 64'(ring_pos), 64'(pos_before));
    send(80); send(80); send(80);
    chk("R5 prod wraps mod 2^16", 64'(prod_idx), 64'd1);
    chk("R5 pending across wrap", 64'(pending), 1);

    // R9 with different thresholds: low 2, high 8
    fc_thresh = {16'd2, 16'd8};
    for (int i = 0; i < 250; i++) send(90);
    chk("R9 no xoff at free=3", 64'(xoff), 0);
    send(90);
    chk("R9 xoff at free=2", 64'(xoff), 1);
    repeat (6) consume();
    chk("R9 xoff held at free=8", 64'(xoff), 1);
    consume();
    chk("R9 xoff released at free=9", 64'(xoff), 0);

    step();
    finish_run();
  end

endmodule